// File: doc/BRIEF.md
# CHS Sector Address Sequencer

This block turns a cylinder/head/sector request, as carried in a disk command block, into a zero-based linear block number. It also checks the request against the drive geometry the controller has been given. A multi-sector transfer is handled by strobing `next` after each sector. The block then advances the sector, wraps it into the head and then into the cylinder, and produces the next block number.

The block also tracks where the heads currently sit. A seek moves that position. Stepping past the last head of a cylinder moves it forward by one, but never beyond the final cylinder. Any request whose cylinder differs from the head position is rejected with an address sense code.

The block number is formed by two passes of a shift-and-add multiplier, first by the head count and then by the sectors per track. A parameter can replace this with a single-cycle multiply. While a computation runs, `busy` is high and all strobes are ignored. When the computation ends, `done` pulses for one cycle. In that cycle `fault`, `sense` and, on success, `lba` are valid.

Top module: `chs_seq`

## Requirements
- R1: For an accepted request the block pulses `done` for exactly one cycle and, when `fault` is low, `lba` equals (cylinder × geo_heads + head) × geo_spt + sector, where all three coordinates count from 0.
- R2: If the requested cylinder differs from `cur_cyl` when the address is checked, `done` comes with `fault` = 1 and `sense` = 0x21.
- R3: If the head is greater than or equal to `geo_heads`, `done` comes with `fault` = 1 and `sense` = 0x21.
- R4: If the sector is greater than or equal to `geo_spt`, `done` comes with `fault` = 1 and `sense` = 0x21; a good address gives `fault` = 0 and `sense` = 0x00.
- R5: `start` loads a remaining count of `cmd_cnt`, where a value of 0 stands for 256. Each accepted `next` lowers the count by one. `last_blk` is high exactly when the remaining count is 1.
- R6: An accepted `next` adds one to the sector. When the sector reaches `geo_spt` it becomes 0 and the head advances. When the head reaches `geo_heads` it becomes 0 and the requested cylinder advances. The new position is then checked and converted as in R1 to R4.
- R7: When a step wraps the head, `cur_cyl` advances by one, but it never exceeds `geo_cyls` − 1.
- R8: A `seek` sets the requested cylinder to `cmd_cyl` and sets `cur_cyl` to `cmd_cyl`, or to `geo_cyls` − 1 when `cmd_cyl` ≥ `geo_cyls`. In the following cycle `fault`/`sense` read 1/0x15 if the two values differ, and 0/0x00 otherwise.
- R9: While `busy` is high, every strobe is ignored. A `next` while `last_blk` is high is ignored as well: no `done` follows, and the position and count stay unchanged. When several strobes arrive together, `start` wins over `seek`, and `seek` wins over `next`.
- R10: After reset, `cur_cyl` = 0, `fault` = 0, `sense` = 0x00, and `busy`, `done` and `last_blk` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load the command-block triple and count, then convert |
| next | input | 1 | Step to the following sector, then convert |
| seek | input | 1 | Move the head position to `cmd_cyl` |
| cmd_cyl | input | CYL_W | Requested cylinder |
| cmd_head | input | HEAD_W | Requested head |
| cmd_sec | input | SEC_W | Requested sector (zero-based) |
| cmd_cnt | input | CNT_W | Sector count (0 means 256) |
| geo_cyls | input | CYL_W | Cylinders on the drive |
| geo_heads | input | HEAD_W | Heads per cylinder |
| geo_spt | input | SEC_W | Sectors per track |
| lba | output | CYL_W+HEAD_W+SEC_W | Linear block number |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Error flag of the last request or seek |
| sense | output | 8 | Sense code: 0x00, 0x15 or 0x21 |
| last_blk | output | 1 | Remaining count is 1 |
| cur_cyl | output | CYL_W | Current head-position cylinder |
| busy | output | 1 | Conversion in progress |

## Verification
The assertions check the following on every cycle:
- the result strobe and the multiplier strobe never last two cycles;
- every faulted result carries the address sense code;
- a seek leaves `cur_cyl` below the cylinder count and sets `fault` exactly when the head position differs from the request;
- a step never reaches the stepper when one sector or none remains;
- a loaded count is never zero;
- the sector after a step is always inside the track.

Only the bench scenarios can show the rest:
- that the block number is arithmetically right;
- that a zero count really runs 256 sectors;
- that the head position saturates at the final cylinder during a multi-track run;
- that strobes issued mid-computation leave no trace.

// File: rtl/chs_seq_pkg.sv
`timescale 1ns/1ps
package chs_seq_pkg;
   localparam logic [7:0] SNS_NONE      = 8'h00;
   localparam logic [7:0] SNS_SEEK_MISS = 8'h15;
   localparam logic [7:0] SNS_BAD_ADDR  = 8'h21;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_CHECK,
      ST_MUL_HC,
      ST_MUL_SEC
   } seq_state_e;
endpackage

// File: rtl/chs_seq_mul.sv
`timescale 1ns/1ps
// p = a * b + addend; result strobed on rdy
module chs_seq_mul #(
   parameter int P_W        = 21,
   parameter int B_W        = 6,
   parameter bit SEQUENTIAL = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           go,
   input  logic [P_W-1:0] a,
   input  logic [B_W-1:0] b,
   input  logic [P_W-1:0] addend,
   output logic           rdy,
   output logic [P_W-1:0] p
);
   generate
      if (B_W < 2) begin : g_bad_bw
         $error("chs_seq_mul: B_W must be at least 2");
      end

      if (SEQUENTIAL) begin : g_seq
         localparam int CW = $clog2(B_W + 1);
         logic [P_W-1:0] acc, mc;
         logic [B_W-1:0] mp;
         logic [CW-1:0]  left;
         logic           run, rdy_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               acc   <= '0;
               mc    <= '0;
               mp    <= '0;
               left  <= '0;
               run   <= 1'b0;
               rdy_q <= 1'b0;
            end else begin
               rdy_q <= 1'b0;
               if (go) begin
                  acc  <= addend;
                  mc   <= a;
                  mp   <= b;
                  left <= CW'(B_W);
                  run  <= 1'b1;
               end else if (run) begin
                  if (mp[0]) acc <= acc + mc;
                  mc   <= mc << 1;
                  mp   <= mp >> 1;
                  left <= left - CW'(1);
                  if (left == CW'(1)) begin
                     run   <= 1'b0;
                     rdy_q <= 1'b1;
                  end
               end
            end
         end

         assign rdy = rdy_q;
         assign p   = acc;

         // R1: a multiplier result is a single-cycle strobe
         assert_mul_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
            rdy |=> !rdy) else $error("multiplier strobe held");
      end else begin : g_comb
         logic [P_W-1:0] p_q;
         logic           rdy_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               p_q   <= '0;
               rdy_q <= 1'b0;
            end else begin
               rdy_q <= go;
               if (go) p_q <= a * P_W'(b) + addend;
            end
         end

         assign rdy = rdy_q;
         assign p   = p_q;
      end
   endgenerate
endmodule

// File: rtl/chs_seq_chk.sv
`timescale 1ns/1ps
module chs_seq_chk #(
   parameter int CYL_W  = 10,
   parameter int HEAD_W = 5,
   parameter int SEC_W  = 6
) (
   input  logic [CYL_W-1:0]  trk,
   input  logic [CYL_W-1:0]  cur_cyl,
   input  logic [HEAD_W-1:0] hd,
   input  logic [SEC_W-1:0]  sc,
   input  logic [HEAD_W-1:0] geo_heads,
   input  logic [SEC_W-1:0]  geo_spt,
   output logic              bad
);
   always_comb begin
      bad = (trk != cur_cyl) || (hd >= geo_heads) || (sc >= geo_spt);
   end
endmodule

// File: rtl/chs_seq_pos.sv
`timescale 1ns/1ps
// Position registers: requested triple, remaining count, head cylinder
module chs_seq_pos #(
   parameter int CYL_W  = 10,
   parameter int HEAD_W = 5,
   parameter int SEC_W  = 6,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              seek,
   input  logic [CYL_W-1:0]  in_cyl,
   input  logic [HEAD_W-1:0] in_head,
   input  logic [SEC_W-1:0]  in_sec,
   input  logic [CNT_W-1:0]  in_cnt,
   input  logic [CYL_W-1:0]  geo_cyls,
   input  logic [HEAD_W-1:0] geo_heads,
   input  logic [SEC_W-1:0]  geo_spt,
   output logic [CYL_W-1:0]  trk,
   output logic [HEAD_W-1:0] hd,
   output logic [SEC_W-1:0]  sc,
   output logic [CNT_W:0]    left,
   output logic [CYL_W-1:0]  cur_cyl,
   output logic              seek_miss
);
   localparam int LEFT_W = CNT_W + 1;

   logic [SEC_W:0]   sc_inc;
   logic [HEAD_W:0]  hd_inc;
   logic [CYL_W:0]   cur_inc;
   logic [CYL_W-1:0] last_cyl, seek_tgt;
   logic             sc_wrap, hd_wrap;

   always_comb begin
      sc_inc    = {1'b0, sc} + (SEC_W + 1)'(1);
      hd_inc    = {1'b0, hd} + (HEAD_W + 1)'(1);
      cur_inc   = {1'b0, cur_cyl} + (CYL_W + 1)'(1);
      sc_wrap   = sc_inc >= {1'b0, geo_spt};
      hd_wrap   = hd_inc >= {1'b0, geo_heads};
      last_cyl  = geo_cyls - CYL_W'(1);
      seek_miss = in_cyl >= geo_cyls;
      seek_tgt  = seek_miss ? last_cyl : in_cyl;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trk     <= '0;
         hd      <= '0;
         sc      <= '0;
         left    <= '0;
         cur_cyl <= '0;
      end else if (load) begin
         trk  <= in_cyl;
         hd   <= in_head;
         sc   <= in_sec;
         left <= (in_cnt == '0) ? (LEFT_W'(1) << CNT_W) : {1'b0, in_cnt};
      end else if (seek) begin
         trk     <= in_cyl;
         cur_cyl <= seek_tgt;
      end else if (step) begin
         left <= left - LEFT_W'(1);
         if (!sc_wrap) begin
            sc <= sc_inc[SEC_W-1:0];
         end else begin
            sc <= '0;
            if (!hd_wrap) begin
               hd <= hd_inc[HEAD_W-1:0];
            end else begin
               hd      <= '0;
               trk     <= trk + CYL_W'(1);
               cur_cyl <= (cur_inc >= {1'b0, geo_cyls}) ? last_cyl : cur_inc[CYL_W-1:0];
            end
         end
      end
   end

   // R5: a freshly loaded count is never zero
   assert_count_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> left != '0) else $error("zero count after load");
   // R9: the controller never steps once the final sector is reached
   assert_no_step_at_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> left > LEFT_W'(1)) else $error("step with count <= 1");
   // R6: after a step the sector is inside the track
   assert_sec_in_track_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !seek && geo_spt != '0) |=> sc < $past(geo_spt))
      else $error("sector past track end");
   // R8: a seek leaves the head position on the drive
   assert_seek_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (seek && !load && geo_cyls != '0) |=> cur_cyl < $past(geo_cyls))
      else $error("head position off the drive");
endmodule

// File: rtl/chs_seq.sv
`timescale 1ns/1ps
module chs_seq
   import chs_seq_pkg::*;
#(
   parameter int CYL_W   = 10,
   parameter int HEAD_W  = 5,
   parameter int SEC_W   = 6,
   parameter int CNT_W   = 8,
   parameter bit SEQ_MUL = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic                          next,
   input  logic                          seek,
   input  logic [CYL_W-1:0]              cmd_cyl,
   input  logic [HEAD_W-1:0]             cmd_head,
   input  logic [SEC_W-1:0]              cmd_sec,
   input  logic [CNT_W-1:0]              cmd_cnt,
   input  logic [CYL_W-1:0]              geo_cyls,
   input  logic [HEAD_W-1:0]             geo_heads,
   input  logic [SEC_W-1:0]              geo_spt,
   output logic [CYL_W+HEAD_W+SEC_W-1:0] lba,
   output logic                          done,
   output logic                          fault,
   output logic [7:0]                    sense,
   output logic                          last_blk,
   output logic [CYL_W-1:0]              cur_cyl,
   output logic                          busy
);
   localparam int LBA_W   = CYL_W + HEAD_W + SEC_W;
   localparam int MUL_B_W = (HEAD_W > SEC_W) ? HEAD_W : SEC_W;
   localparam int LEFT_W  = CNT_W + 1;

   generate
      if (CYL_W < 1 || HEAD_W < 1 || SEC_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("chs_seq: all field widths must be positive");
      end
   endgenerate

   seq_state_e        state;
   logic              idle, acc_start, acc_seek, acc_next, bad;
   logic [CYL_W-1:0]  trk;
   logic [HEAD_W-1:0] hd;
   logic [SEC_W-1:0]  sc;
   logic [CNT_W:0]    left;
   logic              seek_miss;
   logic              mul_go, mul_rdy;
   logic [LBA_W-1:0]  mul_a, mul_add, mul_p;
   logic [MUL_B_W-1:0] mul_b;

   always_comb begin
      idle      = (state == ST_IDLE);
      acc_start = idle && start;
      acc_seek  = idle && seek && !start;
      acc_next  = idle && next && !start && !seek && (left > LEFT_W'(1));
   end

   chs_seq_pos #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W), .CNT_W(CNT_W)) u_pos (
      .clk(clk), .rst_n(rst_n), .load(acc_start), .step(acc_next), .seek(acc_seek),
      .in_cyl(cmd_cyl), .in_head(cmd_head), .in_sec(cmd_sec), .in_cnt(cmd_cnt),
      .geo_cyls(geo_cyls), .geo_heads(geo_heads), .geo_spt(geo_spt),
      .trk(trk), .hd(hd), .sc(sc), .left(left), .cur_cyl(cur_cyl), .seek_miss(seek_miss)
   );

   chs_seq_chk #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W)) u_chk (
      .trk(trk), .cur_cyl(cur_cyl), .hd(hd), .sc(sc),
      .geo_heads(geo_heads), .geo_spt(geo_spt), .bad(bad)
   );

   // first pass: trk * heads + hd; second pass: that * spt + sc
   always_comb begin
      if (state == ST_MUL_HC) begin
         mul_a   = mul_p;
         mul_b   = MUL_B_W'(geo_spt);
         mul_add = LBA_W'(sc);
      end else begin
         mul_a   = LBA_W'(trk);
         mul_b   = MUL_B_W'(geo_heads);
         mul_add = LBA_W'(hd);
      end
      mul_go = ((state == ST_CHECK) && !bad) || ((state == ST_MUL_HC) && mul_rdy);
   end

   chs_seq_mul #(.P_W(LBA_W), .B_W(MUL_B_W), .SEQUENTIAL(SEQ_MUL)) u_mul (
      .clk(clk), .rst_n(rst_n), .go(mul_go), .a(mul_a), .b(mul_b),
      .addend(mul_add), .rdy(mul_rdy), .p(mul_p)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         lba   <= '0;
         done  <= 1'b0;
         fault <= 1'b0;
         sense <= SNS_NONE;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (acc_start || acc_next) begin
                  state <= ST_CHECK;
                  fault <= 1'b0;
                  sense <= SNS_NONE;
               end else if (acc_seek) begin
                  fault <= seek_miss;
                  sense <= seek_miss ? SNS_SEEK_MISS : SNS_NONE;
               end
            end
            ST_CHECK: begin
               if (bad) begin
                  fault <= 1'b1;
                  sense <= SNS_BAD_ADDR;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  state <= ST_MUL_HC;
               end
            end
            ST_MUL_HC: if (mul_rdy) state <= ST_MUL_SEC;
            ST_MUL_SEC: begin
               if (mul_rdy) begin
                  lba   <= mul_p;
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = !idle;
   assign last_blk = (left == LEFT_W'(1));

   // R1: result strobe lasts one cycle
   assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) else $error("done held");
   // R2 / R3 / R4: every faulted result carries the address sense code
   assert_fault_sense_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault) |-> sense == SNS_BAD_ADDR) else $error("wrong sense on fault");
   // R8: seek fault reflects whether the head landed on the request
   assert_seek_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_seek |=> fault == (cur_cyl != $past(cmd_cyl))) else $error("seek fault mismatch");
   // R9: a seek strobe during a conversion leaves the head position alone
   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && seek) |=> $stable(cur_cyl)) else $error("seek taken while busy");
endmodule

// File: tb/chs_seq_tb.sv
`timescale 1ns/1ps
module chs_seq_tb;
   localparam int CYL_W = 10, HEAD_W = 5, SEC_W = 6, CNT_W = 8;
   localparam int LBA_W = CYL_W + HEAD_W + SEC_W;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start = 1'b0, next = 1'b0, seek = 1'b0;
   logic [CYL_W-1:0]  cmd_cyl = '0, geo_cyls = '0;
   logic [HEAD_W-1:0] cmd_head = '0, geo_heads = '0;
   logic [SEC_W-1:0]  cmd_sec = '0, geo_spt = '0;
   logic [CNT_W-1:0]  cmd_cnt = '0;
   logic [LBA_W-1:0]  lba;
   logic              done, fault, last_blk, busy;
   logic [7:0]        sense;
   logic [CYL_W-1:0]  cur_cyl;

   int n_run = 0, n_fail = 0;
   int m_trk = 0, m_hd = 0, m_sc = 0, m_left = 0, m_cur = 0;
   int g_cyl = 0, g_hd = 0, g_spt = 0;

   always #10 clk = ~clk;

   chs_seq #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .next(next), .seek(seek),
      .cmd_cyl(cmd_cyl), .cmd_head(cmd_head), .cmd_sec(cmd_sec), .cmd_cnt(cmd_cnt),
      .geo_cyls(geo_cyls), .geo_heads(geo_heads), .geo_spt(geo_spt),
      .lba(lba), .done(done), .fault(fault), .sense(sense),
      .last_blk(last_blk), .cur_cyl(cur_cyl), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit model_bad();
      return (m_trk != m_cur) || (m_hd >= g_hd) || (m_sc >= g_spt);
   endfunction

   function automatic int model_lba();
      return (m_trk * g_hd + m_hd) * g_spt + m_sc;
   endfunction

   task automatic set_geo(input int c, input int h, input int s);
      @(negedge clk);
      g_cyl = c; g_hd = h; g_spt = s;
      geo_cyls = CYL_W'(c); geo_heads = HEAD_W'(h); geo_spt = SEC_W'(s);
   endtask

   task automatic wait_and_check(input string req);
      int  t = 0;
      bit  got = 0;
      bit  eb;
      while (t < 400) begin
         if (done) begin got = 1; break; end
         @(negedge clk);
         t++;
      end
      check(got, req, "done seen", got, 1);
      eb = model_bad();
      check(fault == eb, req, "fault", fault, eb);
      check(sense == (eb ? 8'h21 : 8'h00), req, "sense", sense, eb ? 33 : 0);
      if (!eb) check(lba == LBA_W'(model_lba()), req, "lba", lba, model_lba());
      check(last_blk == (m_left == 1), req, "last_blk", last_blk, m_left == 1);
   endtask

   task automatic do_seek(input int c, input string req);
      @(negedge clk);
      cmd_cyl = CYL_W'(c); seek = 1'b1;
      @(negedge clk);
      seek = 1'b0;
      m_trk = c;
      m_cur = (c >= g_cyl) ? g_cyl - 1 : c;
      check(cur_cyl == CYL_W'(m_cur), req, "seek cur_cyl", cur_cyl, m_cur);
      check(fault == (c >= g_cyl), req, "seek fault", fault, c >= g_cyl);
      check(sense == ((c >= g_cyl) ? 8'h15 : 8'h00), req, "seek sense", sense,
            (c >= g_cyl) ? 21 : 0);
   endtask

   task automatic do_start(input int c, input int h, input int s, input int n,
                           input string req);
      @(negedge clk);
      cmd_cyl = CYL_W'(c); cmd_head = HEAD_W'(h); cmd_sec = SEC_W'(s);
      cmd_cnt = CNT_W'(n); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      m_trk = c; m_hd = h; m_sc = s; m_left = (n == 0) ? 256 : n;
      wait_and_check(req);
   endtask

   task automatic model_step();
      m_left--;
      m_sc++;
      if (m_sc >= g_spt) begin
         m_sc = 0;
         m_hd++;
         if (m_hd >= g_hd) begin
            m_hd = 0;
            m_trk = (m_trk + 1) % 1024;
            m_cur = (m_cur + 1 >= g_cyl) ? g_cyl - 1 : m_cur + 1;
         end
      end
   endtask

   task automatic do_next(input string req);
      bit stepping = (m_left > 1);
      logic [LBA_W-1:0] old_lba;
      int seen = 0;
      @(negedge clk);
      old_lba = lba;
      next = 1'b1;
      @(negedge clk);
      next = 1'b0;
      if (stepping) begin
         model_step();
         wait_and_check(req);
         check(cur_cyl == CYL_W'(m_cur), req, "cur_cyl after step", cur_cyl, m_cur);
      end else begin
         for (int k = 0; k < 20; k++) begin
            if (done || busy) seen++;
            @(negedge clk);
         end
         check(seen == 0, req, "ignored next activity", seen, 0);
         check(lba == old_lba, req, "lba unchanged", lba, old_lba);
         check(last_blk == (m_left == 1), req, "last_blk unchanged", last_blk, m_left == 1);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog R1: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(cur_cyl == '0, "R10", "cur_cyl", cur_cyl, 0);
      check(!fault && sense == 8'h00, "R10", "fault/sense", {fault, sense}, 0);
      check(!busy && !done && !last_blk, "R10", "busy/done/last", {busy, done, last_blk}, 0);

      set_geo(5, 2, 17);
      do_seek(3, "R8");
      do_seek(9, "R8");                       // saturates to 4, sense 0x15
      do_start(4, 1, 16, 3, "R1");            // lba 169
      do_next("R7");                          // wraps to cyl 5, head stays 4 -> 0x21
      check(cur_cyl == 10'd4, "R7", "saturated cur_cyl", cur_cyl, 4);
      do_next("R5");                          // count reaches 1
      do_next("R9");                          // ignored at last
      do_start(4, 2, 0, 1, "R3");
      do_start(4, 0, 17, 1, "R4");
      do_start(3, 0, 0, 1, "R2");
      do_start(4, 0, 0, 1, "R5");             // lba 136, last

      // R9: seek and next during a conversion
      @(negedge clk);
      cmd_cyl = 10'd0; cmd_head = 5'd1; cmd_sec = 6'd3; cmd_cnt = 8'd2; start = 1'b1;
      m_trk = 0; m_hd = 1; m_sc = 3; m_left = 2;
      @(negedge clk);
      start = 1'b0; cmd_cyl = 10'd2; seek = 1'b1; next = 1'b1;
      @(negedge clk);
      seek = 1'b0; next = 1'b0;
      wait_and_check("R9");
      check(cur_cyl == 10'd4, "R9", "cur_cyl kept while busy", cur_cyl, 4);

      // R6/R7 plain cylinder crossing
      set_geo(10, 2, 3);
      do_seek(0, "R8");
      do_start(0, 1, 2, 2, "R6");             // lba 5
      do_next("R6");                          // cyl 1 head 0 sec 0 -> lba 6
      check(cur_cyl == 10'd1, "R7", "cur_cyl advanced", cur_cyl, 1);

      // R5 count of zero runs 256 sectors
      set_geo(8, 4, 17);
      do_seek(1, "R8");
      do_start(1, 0, 0, 0, "R5");
      for (int k = 0; k < 255; k++) do_next("R6");
      check(last_blk == 1'b1, "R5", "last after 256", last_blk, 1);
      do_next("R9");

      // random mix
      for (int i = 0; i < 400; i++) begin
         int op;
         if (i % 50 == 0)
            set_geo($urandom_range(2, 40), $urandom_range(1, 16), $urandom_range(1, 63));
         op = $urandom_range(0, 9);
         if (op < 2) begin
            do_seek($urandom_range(0, g_cyl + 3), "R8");
         end else if (op < 6) begin
            int c = ($urandom_range(0, 3) == 0) ? $urandom_range(0, g_cyl) : m_cur;
            do_start(c, $urandom_range(0, g_hd), $urandom_range(0, g_spt),
                     $urandom_range(0, 6), "R1");
         end else begin
            do_next("R6");
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule